// File: doc/BRIEF.md
# Byte-lane memory module decoder

This block sits between a 24-bit address, 16-bit data memory bus and a 1 MB memory module. The module is made of eight banks. Each bank pairs two byte-wide 64K x 8 chips, one for the even byte and one for the odd byte, so each bank holds 64K 16-bit words. The decoder is purely combinational. It checks whether the bus address lies inside the module's window and whether exactly one command strobe is active. From that it drives one active-low chip select per byte lane for each bank. It also drives the module select that enables the data buffers, and the direction of those buffers.

The window starts at C0000H and is 100000H bytes long. That start is not a multiple of the module size, so the bank number is taken from the offset (address minus the base) and not from the raw address bits. Bits 16..1 of the address go straight to every chip as the word address. Address bit 0 and the active-low byte-high enable choose which lanes of the chosen bank are enabled. Word accesses, even-byte accesses and odd-byte accesses are therefore all served.

Top module: `lane_module_decoder`

## Requirements
- R1: The access is inside the window exactly when C0000H <= addr < 1C0000H. Addresses BFFFFH and 1C0000H are outside.
- R2: For an active access inside the window, the bank index is bits 19..17 of (addr - C0000H). Only that bank's selects may go low, so C0000H selects bank 0 and 1BFFFFH selects bank 7.
- R3: The low-lane select cs_lo_n[bank] is low only when addr[0] is 0. When addr[0] is 1, every low-lane select stays high.
- R4: The high-lane select cs_hi_n[bank] is low only when bhe_n is 0. When bhe_n is 1, every high-lane select stays high.
- R5: When both mrd_n and mwr_n are high, all sixteen chip selects and mod_sel_n are high and buf_dir is 0.
- R6: When mrd_n and mwr_n are both low, the command is a clash and is treated as no access, with the same outputs as in R5.
- R7: mod_sel_n is low exactly when the address is inside the window and exactly one strobe is low.
- R8: buf_dir is 1 (memory drives the bus) only during a selected read. It is 0 for a selected write and whenever the module is not selected.
- R9: word_addr always equals addr[16:1], whatever the strobes or the window.
- R10: For an address outside the window, every chip select and mod_sel_n stay high under every strobe and lane combination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 24 | Byte address from the bus |
| bhe_n | input | 1 | Byte-high enable, active low |
| mrd_n | input | 1 | Memory read strobe, active low |
| mwr_n | input | 1 | Memory write strobe, active low |
| word_addr | output | 16 | Word address shared by all chips (addr[16:1]) |
| cs_lo_n | output | 8 | Per-bank even-byte chip selects, active low |
| cs_hi_n | output | 8 | Per-bank odd-byte chip selects, active low |
| mod_sel_n | output | 1 | Module select, enables the data buffers, active low |
| buf_dir | output | 1 | Buffer direction: 1 toward the bus, 0 toward the memory |

## Verification
The block holds no state, so an error in the window subtraction, the bank extraction or the command decode shows on the ports for the vector that triggers it. The fault appears as a select in the wrong bank, a second lane that should stay high, or a module select at a boundary address. The sweep steps through the whole 24-bit space in 4 KB strides, crossing every bank edge and both window edges. At each point it applies every combination of strobes, byte-high enable and address bit 0. A mistake near an edge is therefore seen on the first vector that crosses that edge.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE  = 2'b00,
      CMD_READ  = 2'b01,
      CMD_WRITE = 2'b10,
      CMD_CLASH = 2'b11
   } cmd_e;

   // Strobes are active low; both low is a clash.
   function automatic cmd_e decode_cmd(input logic rd_n, input logic wr_n);
      cmd_e c;
      unique case ({!wr_n, !rd_n})
         2'b01:   c = CMD_READ;
         2'b10:   c = CMD_WRITE;
         2'b11:   c = CMD_CLASH;
         default: c = CMD_IDLE;
      endcase
      return c;
   endfunction

   function automatic logic cmd_active(input cmd_e c);
      return (c == CMD_READ) || (c == CMD_WRITE);
   endfunction

endpackage

// File: rtl/mdec_window.sv
module mdec_window #(
   parameter int          ADDR_W = 24,
   parameter logic [31:0] BASE   = 32'h000C_0000,
   parameter logic [31:0] SIZE   = 32'h0010_0000,
   parameter int          LOW_W  = 17,
   parameter int          BANK_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_win,
   output logic [BANK_W-1:0] bank_idx
);
   localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(BASE);
   localparam logic [ADDR_W:0] SIZE_X = (ADDR_W+1)'(SIZE);

   initial begin
      assert_cfg_fit_R1: assert ((64'(BASE) + 64'(SIZE)) <= (64'(1) << ADDR_W))
         else $error("window exceeds address space");
      assert_cfg_bankalign_R2: assert ((BASE % (32'(1) << LOW_W)) == 0)
         else $error("base not aligned to bank size");
      assert_cfg_span_R2: assert (64'(SIZE) == (64'(1) << (LOW_W + BANK_W)))
         else $error("window size does not match bank count");
   end

   logic [ADDR_W:0] diff;

   always_comb begin
      diff     = {1'b0, addr} - BASE_X;
      in_win   = !diff[ADDR_W] && (diff < SIZE_X);
      bank_idx = diff[LOW_W +: BANK_W];
      // R1: an address below the base can never be taken as inside
      assert_below_base_R1: assert (!(in_win && ({1'b0, addr} < BASE_X)));
   end

endmodule

// File: rtl/mdec_bank_dec.sv
module mdec_bank_dec #(
   parameter int BANKS  = 8,
   parameter int BANK_W = $clog2(BANKS)
) (
   input  logic [BANK_W-1:0] idx,
   input  logic              en,
   output logic [BANKS-1:0]  hot
);
   initial begin
      assert_cfg_banks_R2: assert (BANKS == (1 << BANK_W))
         else $error("bank count must be a power of two");
   end

   for (genvar g = 0; g < BANKS; g++) begin : g_bank
      assign hot[g] = en && (idx == BANK_W'(g));
   end

   always_comb begin
      assert_onehot_R2: assert (en ? $onehot(hot) : (hot == '0));
   end

endmodule

// File: rtl/mdec_lane_split.sv
module mdec_lane_split #(
   parameter int BANKS = 8
) (
   input  logic [BANKS-1:0] hot,
   input  logic             a0,
   input  logic             bhe_n,
   output logic [BANKS-1:0] cs_lo_n,
   output logic [BANKS-1:0] cs_hi_n
);
   always_comb begin
      cs_lo_n = ~(hot & {BANKS{!a0}});
      cs_hi_n = ~(hot & {BANKS{!bhe_n}});
      assert_lo_odd_R3: assert (!a0 || (&cs_lo_n));
      assert_hi_off_R4: assert (!bhe_n || (&cs_hi_n));
   end

endmodule

// File: rtl/mdec_buf_ctl.sv
module mdec_buf_ctl
   import mdec_pkg::*;
(
   input  logic in_win,
   input  cmd_e cmd,
   output logic mod_sel_n,
   output logic buf_dir
);
   always_comb begin
      mod_sel_n = !(in_win && cmd_active(cmd));
      buf_dir   = in_win && (cmd == CMD_READ);
      assert_dir_sel_R8: assert (!buf_dir || !mod_sel_n);
   end

endmodule

// File: rtl/lane_module_decoder.sv
module lane_module_decoder
   import mdec_pkg::*;
#(
   parameter int          ADDR_W  = 24,
   parameter int          WORD_AW = 16,
   parameter int          BANKS   = 8,
   parameter logic [31:0] BASE    = 32'h000C_0000
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic               bhe_n,
   input  logic               mrd_n,
   input  logic               mwr_n,
   output logic [WORD_AW-1:0] word_addr,
   output logic [BANKS-1:0]   cs_lo_n,
   output logic [BANKS-1:0]   cs_hi_n,
   output logic               mod_sel_n,
   output logic               buf_dir
);
   localparam int          BANK_W = $clog2(BANKS);
   localparam int          LOW_W  = WORD_AW + 1;
   localparam logic [31:0] SIZE   = 32'(BANKS) << LOW_W;

   cmd_e              cmd;
   logic              in_win;
   logic              bank_en;
   logic [BANK_W-1:0] bank_idx;
   logic [BANKS-1:0]  bank_hot;

   assign cmd       = decode_cmd(mrd_n, mwr_n);
   assign bank_en   = in_win && cmd_active(cmd);
   assign word_addr = addr[WORD_AW:1];

   mdec_window #(
      .ADDR_W(ADDR_W), .BASE(BASE), .SIZE(SIZE),
      .LOW_W(LOW_W), .BANK_W(BANK_W)
   ) u_window (
      .addr(addr), .in_win(in_win), .bank_idx(bank_idx)
   );

   mdec_bank_dec #(.BANKS(BANKS), .BANK_W(BANK_W)) u_bank (
      .idx(bank_idx), .en(bank_en), .hot(bank_hot)
   );

   mdec_lane_split #(.BANKS(BANKS)) u_lane (
      .hot(bank_hot), .a0(addr[0]), .bhe_n(bhe_n),
      .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n)
   );

   mdec_buf_ctl u_buf (
      .in_win(in_win), .cmd(cmd), .mod_sel_n(mod_sel_n), .buf_dir(buf_dir)
   );

endmodule

// File: tb/lane_module_decoder_tb.sv
module lane_module_decoder_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYC   = 190000;

   logic        clk = 1'b0;
   logic [23:0] addr = '0;
   logic        bhe_n = 1'b1, mrd_n = 1'b1, mwr_n = 1'b1;
   logic [15:0] word_addr;
   logic [7:0]  cs_lo_n, cs_hi_n;
   logic        mod_sel_n, buf_dir;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lane_module_decoder u_dut (
      .addr(addr), .bhe_n(bhe_n), .mrd_n(mrd_n), .mwr_n(mwr_n),
      .word_addr(word_addr), .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n),
      .mod_sel_n(mod_sel_n), .buf_dir(buf_dir)
   );

   task automatic apply(input logic [23:0] a, input logic bh, input logic rd, input logic wr);
      bit          rd_act, wr_act, act, inw, sel, bad;
      int unsigned off;
      logic [2:0]  bank;
      logic [7:0]  e_lo, e_hi;
      logic        e_ms, e_dir;
      logic [15:0] e_wa;
      @(negedge clk);
      addr = a; bhe_n = bh; mrd_n = rd; mwr_n = wr;
      #(CLK_PERIOD/4);
      rd_act = !rd && wr;
      wr_act = !wr && rd;
      act    = rd_act || wr_act;
      inw    = (int'(a) >= 'hC0000) && (int'(a) < 'h1C0000);
      sel    = act && inw;
      off    = int'(a) - 'hC0000;
      bank   = 3'((off >> 17) & 7);
      e_lo   = 8'hFF; e_hi = 8'hFF;
      if (sel && !a[0]) e_lo[bank] = 1'b0;
      if (sel && !bh)   e_hi[bank] = 1'b0;
      e_ms   = !sel;
      e_dir  = sel && rd_act;
      e_wa   = 16'((int'(a) >> 1) & 'hFFFF);
      bad    = 0;
      vectors++;
      if (cs_lo_n !== e_lo) begin
         bad = 1;
         $display("FAIL R2/R3 a=%h bhe=%b rd=%b wr=%b cs_lo_n=%h exp=%h", a, bh, rd, wr, cs_lo_n, e_lo);
      end
      if (cs_hi_n !== e_hi) begin
         bad = 1;
         $display("FAIL R2/R4 a=%h bhe=%b rd=%b wr=%b cs_hi_n=%h exp=%h", a, bh, rd, wr, cs_hi_n, e_hi);
      end
      if (mod_sel_n !== e_ms) begin
         bad = 1;
         $display("FAIL R1/R7 a=%h rd=%b wr=%b mod_sel_n=%b exp=%b", a, rd, wr, mod_sel_n, e_ms);
      end
      if (buf_dir !== e_dir) begin
         bad = 1;
         $display("FAIL R8 a=%h rd=%b wr=%b buf_dir=%b exp=%b", a, rd, wr, buf_dir, e_dir);
      end
      if (word_addr !== e_wa) begin
         bad = 1;
         $display("FAIL R9 a=%h word_addr=%h exp=%h", a, word_addr, e_wa);
      end
      if (bad) miscompares++;
   endtask

   // every lane and strobe combination at one address
   task automatic sweep_point(input logic [23:0] a);
      for (int c = 0; c < 8; c++) begin
         for (int b0 = 0; b0 < 2; b0++) begin
            apply({a[23:1], 1'(b0)}, c[2], c[1], c[0]);
         end
      end
   endtask

   initial begin : watchdog
      repeat (WDOG_CYC) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired after %0d cycles exp=completion", WDOG_CYC);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin : main
      // R5: idle bus at start, all selects inactive
      apply(24'hC0000, 1'b0, 1'b1, 1'b1);
      // R6: clash at a valid address behaves as no access
      apply(24'hC0000, 1'b0, 1'b0, 1'b0);
      // R1 / R10 boundaries, R2 bank edges
      sweep_point(24'h0BFFFE);
      sweep_point(24'h0BFFFF);
      sweep_point(24'h0C0000);
      sweep_point(24'h0DFFFF);
      sweep_point(24'h0E0000);
      sweep_point(24'h1BFFFF);
      sweep_point(24'h1C0000);
      sweep_point(24'h000000);
      sweep_point(24'hFFFFFF);
      sweep_point(24'h2C0000);
      // R1..R10: strided sweep of the whole address space
      for (int i = 0; i < 4096; i++) begin
         sweep_point(24'((i << 12) | ((i * 1237) & 'hFFF)));
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule